// File: doc/BRIEF.md
# Serial Real-Time-Clock Access Port

This block is the three-wire host port of a real-time clock. A host raises a chip enable and picks a direction. It then toggles a shift clock while data moves one bit per rising edge over a single data line. The line is split here into an input, an output and an output enable.

In read mode, the first rising edge takes a snapshot of the calendar word from the counter core. The word is then sent least significant bit first. In write mode, the port collects a complete 52-bit word and hands it to the counter core as a single one-cycle load. It also tells the core when to stop the seconds tick and when to reset the sub-second divider.

The port holds two bits of the frame itself: the supply-fail flag and the test bit. The supply-fail flag is set by a voltage-detect pulse from the core. The frame width is fixed at 52 bits:

| Frame bits | Field |
|---|---|
| 0-6 | seconds |
| 7 | supply-fail flag |
| 8-15 | minutes |
| 16-23 | hours |
| 24-27 | weekday |
| 28-35 | day |
| 36-43 | month, with the test bit at 43 |
| 44-51 | year |

All host pins are oversampled in the system clock domain through synchronizer stages.

Top module: `rtc_serial_port`

## Requirements
- R1: While chip enable is low, the data output enable is 0, shift-clock edges have no effect, and the bit count and direction restart at zero for the next access.
- R2: The direction input is taken at the first rising shift-clock edge of an access. Level 1 selects write mode, in which the output enable stays 0. Level 0 selects read mode, in which the output enable is 1.
- R3: In read mode, the first rising edge loads the snapshot and shows frame bit 0 on the data output. Rising edge k shows frame bit k-1.
- R4: The frame is laid out with seconds in bits 0-6, the supply-fail flag at bit 7, minutes in 8-15, hours in 16-23, weekday in 24-27, day in 28-35, month in 36-43 with the test bit at 43, and year in 44-51. Bits 7 and 43 of a read come from the port's own flag and test bit, not from the time input.
- R5: Rising edges after the 52nd change nothing. In a read, the data output keeps showing frame bit 51.
- R6: A one-cycle pulse on the detect input sets the supply-fail flag, which is then read at frame bit 7.
- R7: A read of 48 or more rising edges clears the supply-fail flag. A read of 47 or fewer leaves it set.
- R8: After exactly 52 rising edges in write mode, the port gives one single-cycle load pulse carrying the received word. Bit i of the word is the bit sampled on rising edge i+1. The same commit copies word bit 7 into the supply-fail flag and word bit 43 into the test bit.
- R9: A write in which chip enable falls before the 52nd rising edge gives no load pulse.
- R10: In a write, data on rising edges from the 53rd onward is ignored, and no second load pulse follows.
- R11: In write mode, the freeze output rises at the first falling shift-clock edge. It stays high after chip enable falls, and clears only on the next rising edge of chip enable.
- R12: In write mode, the divider-reset output is high between the first and second rising shift-clock edges and low otherwise.
- R13: The test bit is cleared whenever chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| ce_i | input | 1 | host chip enable |
| wr_i | input | 1 | direction, 1 write and 0 read |
| sclk_i | input | 1 | host shift clock |
| sdata_i | input | 1 | serial data from host |
| sdata_o | output | 1 | serial data to host |
| sdata_oe_o | output | 1 | drive enable for the data line |
| time_i | input | 52 | current calendar word from counter core |
| det_i | input | 1 | low-voltage detect pulse |
| freeze_o | output | 1 | stop the seconds tick |
| div_rst_o | output | 1 | reset the sub-second divider |
| load_o | output | 1 | one-cycle commit strobe |
| load_data_o | output | 52 | committed calendar word |
| fail_flag_o | output | 1 | supply-fail flag |
| test_o | output | 1 | test bit |

## Verification
The bench uses the default two synchronizer stages and a full 52-bit frame. It holds each shift-clock phase for eight system clocks, so every bit is checked after its synchronized edge has settled. It sweeps every read length from 0 to 53 edges, which places both sides of the 47/48 flag-clear boundary and the hold-after-52 behaviour within reach. Writes of 1, 2, 51, 52, 53 and 60 edges cover the discard, exact-commit and overflow cases, together with the freeze and divider-reset timing.

// File: rtl/rtc_ser_pkg.sv
package rtc_ser_pkg;
  localparam int FRAME_BITS_D = 52;  // full calendar frame
  localparam int FLAG_POS_D   = 7;   // supply-fail flag in seconds byte
  localparam int TEST_POS_D   = 43;  // test bit in month byte
  localparam int CLEAR_MIN_D  = 48;  // read length that clears the flag
  localparam int SYNC_D       = 2;   // synchronizer depth
endpackage

// File: rtl/rtc_ser_sync.sv
module rtc_ser_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= '0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rtc_ser_shift.sv
module rtc_ser_shift #(
  parameter int FB    = 52,
  parameter int CNT_W = $clog2(FB + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_s,
  input  logic             sclk_s,
  input  logic             wr_s,
  input  logic             din_s,
  input  logic [FB-1:0]    snap_i,
  output logic             fall_o,
  output logic             ce_rise_o,
  output logic             step_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             started_o,
  output logic             mode_wr_o,
  output logic             dout_o,
  output logic             oe_o,
  output logic             commit_o,
  output logic [FB-1:0]    word_o
);
  logic          sclk_d, ce_d;
  logic [FB-1:0] sr;
  logic          rise, fall_c, more, last, cur_wr;

  assign rise   = ce_s & sclk_s & ~sclk_d;
  assign fall_c = ce_s & ~sclk_s & sclk_d;
  assign more   = cnt_o < CNT_W'(FB);
  assign last   = cnt_o == CNT_W'(FB - 1);
  assign cur_wr = started_o ? mode_wr_o : wr_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d    <= 1'b0;
      ce_d      <= 1'b0;
      fall_o    <= 1'b0;
      ce_rise_o <= 1'b0;
      step_o    <= 1'b0;
      commit_o  <= 1'b0;
      cnt_o     <= '0;
      started_o <= 1'b0;
      mode_wr_o <= 1'b0;
      oe_o      <= 1'b0;
      dout_o    <= 1'b0;
    end else begin
      sclk_d    <= sclk_s;
      ce_d      <= ce_s;
      fall_o    <= fall_c;
      ce_rise_o <= ce_s & ~ce_d;
      step_o    <= 1'b0;
      commit_o  <= 1'b0;
      if (!ce_s) begin
        cnt_o     <= '0;
        started_o <= 1'b0;
        mode_wr_o <= 1'b0;
        oe_o      <= 1'b0;
        dout_o    <= 1'b0;
      end else begin
        oe_o <= ~cur_wr;
        if (rise && more) begin
          cnt_o  <= cnt_o + 1'b1;
          step_o <= 1'b1;
          if (!started_o) begin
            started_o <= 1'b1;
            mode_wr_o <= wr_s;
          end
          if (cur_wr) commit_o <= last;
          else        dout_o   <= started_o ? sr[0] : snap_i[0];
        end
      end
    end
  end

  // datapath registers carry no reset
  always_ff @(posedge clk) begin
    if (ce_s && rise && more) begin
      if (cur_wr) begin
        sr <= {din_s, sr[FB-1:1]};
        if (last) word_o <= {din_s, sr[FB-1:1]};
      end else begin
        sr <= started_o ? (sr >> 1) : (snap_i >> 1);
      end
    end
  end
endmodule

// File: rtl/rtc_ser_status.sv
module rtc_ser_status #(
  parameter int FB        = 52,
  parameter int CNT_W     = $clog2(FB + 1),
  parameter int FLAG_POS  = 7,
  parameter int TEST_POS  = 43,
  parameter int CLEAR_MIN = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_s,
  input  logic             fall_i,
  input  logic             ce_rise_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             started_i,
  input  logic             mode_wr_i,
  input  logic             commit_i,
  input  logic [FB-1:0]    word_i,
  input  logic             det_i,
  output logic             freeze_o,
  output logic             div_rst_o,
  output logic             flag_o,
  output logic             test_o,
  output logic             load_o,
  output logic [FB-1:0]    load_data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      freeze_o  <= 1'b0;
      div_rst_o <= 1'b0;
      flag_o    <= 1'b0;
      test_o    <= 1'b0;
      load_o    <= 1'b0;
    end else begin
      load_o    <= commit_i;
      div_rst_o <= ce_s & started_i & mode_wr_i & (cnt_i == CNT_W'(1));

      if (ce_rise_i)                               freeze_o <= 1'b0;
      else if (fall_i && started_i && mode_wr_i)   freeze_o <= 1'b1;

      if (det_i)         flag_o <= 1'b1;
      else if (commit_i) flag_o <= word_i[FLAG_POS];
      else if (step_i && !mode_wr_i && cnt_i == CNT_W'(CLEAR_MIN))
                         flag_o <= 1'b0;

      if (!ce_s)         test_o <= 1'b0;
      else if (commit_i) test_o <= word_i[TEST_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (commit_i) load_data_o <= word_i;
  end
endmodule

// File: rtl/rtc_serial_port.sv
module rtc_serial_port #(
  parameter int FRAME_BITS  = rtc_ser_pkg::FRAME_BITS_D,
  parameter int FLAG_POS    = rtc_ser_pkg::FLAG_POS_D,
  parameter int TEST_POS    = rtc_ser_pkg::TEST_POS_D,
  parameter int CLEAR_MIN   = rtc_ser_pkg::CLEAR_MIN_D,
  parameter int SYNC_STAGES = rtc_ser_pkg::SYNC_D
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce_i,
  input  logic                  wr_i,
  input  logic                  sclk_i,
  input  logic                  sdata_i,
  output logic                  sdata_o,
  output logic                  sdata_oe_o,
  input  logic [FRAME_BITS-1:0] time_i,
  input  logic                  det_i,
  output logic                  freeze_o,
  output logic                  div_rst_o,
  output logic                  load_o,
  output logic [FRAME_BITS-1:0] load_data_o,
  output logic                  fail_flag_o,
  output logic                  test_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);

  logic                  ce_s, sclk_s, wr_s, din_s;
  logic                  fall, ce_rise, step, started, mode_wr, commit;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] word, snap;

  rtc_ser_sync #(.W(4), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({ce_i, sclk_i, wr_i, sdata_i}),
    .q_o ({ce_s, sclk_s, wr_s, din_s})
  );

  always_comb begin
    snap           = time_i;
    snap[FLAG_POS] = fail_flag_o;
    snap[TEST_POS] = test_o;
  end

  rtc_ser_shift #(.FB(FRAME_BITS), .CNT_W(CNT_W)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .ce_s      (ce_s),
    .sclk_s    (sclk_s),
    .wr_s      (wr_s),
    .din_s     (din_s),
    .snap_i    (snap),
    .fall_o    (fall),
    .ce_rise_o (ce_rise),
    .step_o    (step),
    .cnt_o     (cnt),
    .started_o (started),
    .mode_wr_o (mode_wr),
    .dout_o    (sdata_o),
    .oe_o      (sdata_oe_o),
    .commit_o  (commit),
    .word_o    (word)
  );

  rtc_ser_status #(
    .FB(FRAME_BITS), .CNT_W(CNT_W), .FLAG_POS(FLAG_POS),
    .TEST_POS(TEST_POS), .CLEAR_MIN(CLEAR_MIN)
  ) i_status (
    .clk         (clk),
    .rst         (rst),
    .ce_s        (ce_s),
    .fall_i      (fall),
    .ce_rise_i   (ce_rise),
    .step_i      (step),
    .cnt_i       (cnt),
    .started_i   (started),
    .mode_wr_i   (mode_wr),
    .commit_i    (commit),
    .word_i      (word),
    .det_i       (det_i),
    .freeze_o    (freeze_o),
    .div_rst_o   (div_rst_o),
    .flag_o      (fail_flag_o),
    .test_o      (test_o),
    .load_o      (load_o),
    .load_data_o (load_data_o)
  );
endmodule

// File: rtl/rtc_ser_checker.sv
module rtc_ser_checker #(
  parameter int FB        = 52,
  parameter int CNT_W     = 6,
  parameter int CLEAR_MIN = 48
) (
  input logic             clk,
  input logic             rst,
  input logic             ce_s,
  input logic [CNT_W-1:0] cnt,
  input logic             mode_wr,
  input logic             started,
  input logic             fall,
  input logic             step,
  input logic             commit,
  input logic             sdata_oe_o,
  input logic             load_o,
  input logic             freeze_o,
  input logic             div_rst_o,
  input logic             fail_flag_o,
  input logic             test_o
);
  assert_oe_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> !sdata_oe_o);

  assert_write_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (started && mode_wr) |=> !sdata_oe_o);

  assert_count_cap_R5: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(FB));

  assert_load_after_full_R8: assert property (@(posedge clk) disable iff (rst)
    load_o |-> $past(cnt) == CNT_W'(FB));

  assert_load_single_R10: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o);

  assert_flag_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(fail_flag_o) |-> ($past(commit) ||
      ($past(step) && !$past(mode_wr) && $past(cnt) == CNT_W'(CLEAR_MIN))));

  assert_freeze_rise_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze_o) |-> ($past(fall) && $past(mode_wr)));

  assert_div_window_R12: assert property (@(posedge clk) disable iff (rst)
    div_rst_o |-> ($past(cnt) == CNT_W'(1) && $past(mode_wr)));

  assert_test_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !ce_s |=> !test_o);
endmodule

bind rtc_serial_port rtc_ser_checker #(
  .FB(FRAME_BITS), .CNT_W(CNT_W), .CLEAR_MIN(CLEAR_MIN)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .ce_s        (ce_s),
  .cnt         (cnt),
  .mode_wr     (mode_wr),
  .started     (started),
  .fall        (fall),
  .step        (step),
  .commit      (commit),
  .sdata_oe_o  (sdata_oe_o),
  .load_o      (load_o),
  .freeze_o    (freeze_o),
  .div_rst_o   (div_rst_o),
  .fail_flag_o (fail_flag_o),
  .test_o      (test_o)
);

// File: tb/test_rtc_serial_port.sv
`timescale 1ns/1ps
module test_rtc_serial_port;
  localparam int FB = 52;
  localparam int H  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_i = 1'b0, wr_i = 1'b0, sclk_i = 1'b0, sdata_i = 1'b0, det_i = 1'b0;
  logic          sdata_o, sdata_oe_o, freeze_o, div_rst_o, load_o, fail_flag_o, test_o;
  logic [FB-1:0] time_i = '0;
  logic [FB-1:0] load_data_o;

  int n_tests = 0, n_fail = 0, n_loads = 0;
  logic [FB-1:0] last_load;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_serial_port i_rtc_serial_port (
    .clk(clk), .rst(rst), .ce_i(ce_i), .wr_i(wr_i), .sclk_i(sclk_i),
    .sdata_i(sdata_i), .sdata_o(sdata_o), .sdata_oe_o(sdata_oe_o),
    .time_i(time_i), .det_i(det_i), .freeze_o(freeze_o),
    .div_rst_o(div_rst_o), .load_o(load_o), .load_data_o(load_data_o),
    .fail_flag_o(fail_flag_o), .test_o(test_o)
  );

  always @(negedge clk) if (load_o) begin
    n_loads++;
    last_load = load_data_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [FB-1:0] pat(input int k);
    logic [63:0] x;
    x = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 3);
    return x[FB-1:0] ^ (x[63:12]);
  endfunction

  task automatic pulse_det();
    det_i = 1'b1; wclk(1); det_i = 1'b0; wclk(2);
  endtask

  // read of n rising edges; returns expected word check and flag check
  task automatic do_read(input int n, input logic [FB-1:0] t);
    logic [FB-1:0] e;
    int bad = 0, oe_bad = 0, hold_bad = 0;
    time_i = t;
    e = t; e[7] = fail_flag_o; e[43] = test_o;
    ce_i = 1'b1; wr_i = 1'b0; wclk(H);
    for (int i = 1; i <= n; i++) begin
      sclk_i = 1'b1; wclk(H - 1);
      if (!sdata_oe_o) oe_bad++;
      if (i <= FB) begin
        if (sdata_o !== e[i-1]) bad++;
      end else if (sdata_o !== e[FB-1]) hold_bad++;
      sclk_i = 1'b0; wclk(H);
    end
    if (n > 0) chk(bad == 0 && oe_bad == 0, "R3/R4 read bits", 64'(bad), 64'd0);
    if (n > FB) chk(hold_bad == 0, "R5 hold after 52", 64'(hold_bad), 64'd0);
    ce_i = 1'b0; wclk(2 * H);
    chk(sdata_oe_o == 1'b0, "R1 oe idle", 64'(sdata_oe_o), 64'd0);
  endtask

  task automatic do_write(input int n, input logic [FB-1:0] w);
    int loads0 = n_loads;
    ce_i = 1'b1; wr_i = 1'b1; wclk(H);
    for (int i = 1; i <= n; i++) begin
      sdata_i = (i <= FB) ? w[i-1] : ~w[(i-1) % FB];
      wclk(H);
      sclk_i = 1'b1; wclk(H - 1);
      if (i == 1) chk(div_rst_o == 1'b1, "R12 div reset after first rise", 64'(div_rst_o), 64'd1);
      if (i == 2) chk(div_rst_o == 1'b0, "R12 div reset after second rise", 64'(div_rst_o), 64'd0);
      if (i == 1) chk(sdata_oe_o == 1'b0, "R2 write leaves line", 64'(sdata_oe_o), 64'd0);
      sclk_i = 1'b0; wclk(H);
      if (i == 1) chk(freeze_o == 1'b1, "R11 freeze at first fall", 64'(freeze_o), 64'd1);
    end
    wclk(4);
    if (n >= FB) begin
      chk(n_loads - loads0 == 1, "R8/R10 single load", 64'(n_loads - loads0), 64'd1);
      chk(last_load == w, "R8/R10 load word", 64'(last_load), 64'(w));
      chk(fail_flag_o == w[7], "R8 flag from bit 7", 64'(fail_flag_o), 64'(w[7]));
      chk(test_o == w[43], "R8 test from bit 43", 64'(test_o), 64'(w[43]));
    end else begin
      chk(n_loads == loads0, "R9 short write discarded", 64'(n_loads - loads0), 64'd0);
    end
    ce_i = 1'b0; wr_i = 1'b0; wclk(2 * H);
    chk(test_o == 1'b0, "R13 test cleared on ce low", 64'(test_o), 64'd0);
    if (n > 0) chk(freeze_o == 1'b1, "R11 freeze held after ce low", 64'(freeze_o), 64'd1);
  endtask

  initial begin
    wclk(5);
    rst = 1'b0;
    wclk(2);
    chk(sdata_oe_o == 0 && load_o == 0 && freeze_o == 0 && div_rst_o == 0 &&
        fail_flag_o == 0 && test_o == 0, "R1 reset state",
        {58'd0, sdata_oe_o, load_o, freeze_o, div_rst_o, fail_flag_o, test_o}, 64'd0);

    // R1: shift clock while ce low has no effect
    for (int i = 0; i < 3; i++) begin
      sclk_i = 1'b1; wclk(H); sclk_i = 1'b0; wclk(H);
    end
    chk(sdata_oe_o == 0 && n_loads == 0, "R1 edges ignored while ce low", 64'(n_loads), 64'd0);

    // read length sweep; flag set before each read
    for (int n = 0; n <= FB + 1; n++) begin
      pulse_det();
      chk(fail_flag_o == 1'b1, "R6 detect sets flag", 64'(fail_flag_o), 64'd1);
      do_read(n, pat(n));
      chk(fail_flag_o == ((n >= 48) ? 1'b0 : 1'b1), "R7 flag after read",
          64'(fail_flag_o), 64'((n >= 48) ? 0 : 1));
    end

    // write sweep
    begin
      int lens [6] = '{1, 2, 51, 52, 53, 60};
      foreach (lens[k]) begin
        logic [FB-1:0] w;
        w = pat(100 + k);
        w[7] = k[0]; w[43] = 1'b1;
        do_write(lens[k], w);
        // next access start clears freeze
        ce_i = 1'b1; wclk(H);
        chk(freeze_o == 1'b0, "R11 freeze cleared by ce rise", 64'(freeze_o), 64'd0);
        ce_i = 1'b0; wclk(2 * H);
      end
    end

    // read after a committed write carries the written flag at bit 7
    begin
      logic [FB-1:0] w;
      w = pat(200); w[7] = 1'b1; w[43] = 1'b0;
      do_write(FB, w);
      do_read(20, pat(201));
      chk(fail_flag_o == 1'b1, "R7 short read keeps written flag", 64'(fail_flag_o), 64'd1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule